// File: doc/BRIEF.md
# Shared-Context BIP-8 Parity Engine

This block computes and checks the eight-bit bit-interleaved parity that each SDH/SONET frame carries for the frame sent before it. It does so for many line ports at once. All ports share a single nine-byte data path, and any clock cycle may carry a word from any port. Each word comes with a port number, a start-of-frame marker, a marker for the word that holds the received parity byte, and a flag for words read twice from a port FIFO. The block has one parity unit. In every cycle it reads the context of the addressed port from a register array, updates it, and writes it back.

A port's running parity covers all bytes of its current frame. When that port's next frame starts, the running value becomes the expected parity, and accumulation restarts with the new word. When the parity-byte word of that port arrives, the byte in lane 0 is compared with the expected value. The comparison is reported one cycle later as a result pulse tagged with the port, an error flag and the number of mismatched bits.

Top module: `bip8_ctx_engine`

## Requirements
- R1: After reset, `chk_valid`, `b1_err` and `err_bits` are 0, and every port context is zero: no running parity, no expected value, no frame seen.
- R2: A port's running parity is the XOR of all nine bytes of every accepted word of its current frame. The start-of-frame word and the parity-byte word are included. Lane 0 is bits 7:0 and lane k is bits 8k+7:8k.
- R3: An accepted word with `in_sof`=1 stores the port's running parity as its expected value and restarts the running parity from that word alone. The expected value becomes usable only if the port had already seen a start of frame before this one.
- R4: An accepted word with `in_b1pos`=1, on a port with a usable expected value, produces `chk_valid`=1 for exactly one cycle on the next clock. `chk_port` equals the word's port, and the comparison uses lane 0 of that word.
- R5: During a result pulse, `err_bits` equals the number of set bits in (expected XOR received byte), from 0 to 8, and `b1_err`=1 exactly when that count is non-zero. Outside a pulse, both are 0.
- R6: A word with `in_dup`=1 is ignored. It is not folded into any parity, it latches nothing and it produces no result pulse.
- R7: Each port's context evolves independently of the traffic on other ports. Words of one port may arrive in any interleaving, including back to back in consecutive cycles.
- R8: No result pulse occurs for a port until it has seen two starts of frame since reset.
- R9: A word that carries both `in_sof` and `in_b1pos` is compared against the expected value latched by that same word.
- R10: A cycle with `in_valid`=0 changes no context and produces no result pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A word is present this cycle |
| in_port | input | PW | Port number of the word |
| in_data | input | LANES*8 | Nine data bytes; lane 0 in bits 7:0 |
| in_sof | input | 1 | Word is the first word of a frame |
| in_b1pos | input | 1 | Lane 0 of the word is the received parity byte |
| in_dup | input | 1 | Word was read twice from the port FIFO |
| chk_valid | output | 1 | One-cycle result pulse |
| chk_port | output | PW | Port of the result |
| b1_err | output | 1 | Parity mismatch during the pulse |
| err_bits | output | 4 | Count of mismatched bits |

## Verification
Two functions can coincide on a single word: the start-of-frame latch, and the parity-byte comparison. The bench drives this case directly with a word that carries both markers and a byte that differs from the just-latched value in four bits. It then checks that the pulse reports four bits against the value latched in that same cycle, not the older one. A second collision, a stored context being written and read again in the next cycle, comes from sending back-to-back words of one port, both in directed tests and in random interleaving. The per-port reference model in the bench judges every result.

// File: rtl/bip8_pkg.sv
package bip8_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic [BYTE_W-1:0] acc;      // running parity of the current frame
    logic [BYTE_W-1:0] exp;      // parity of the last complete frame
    logic              primed;   // a start of frame has been seen
    logic              exp_vld;  // exp covers a whole frame
  } port_ctx_t;
endpackage

// File: rtl/bip8_lane_fold.sv
module bip8_lane_fold #(
  parameter int unsigned LANES = 9
) (
  input  logic [LANES*8-1:0] word,
  output logic [7:0]         parity
);
  logic [7:0] chain [LANES+1];

  assign chain[0] = 8'h00;
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign chain[g+1] = chain[g] ^ word[g*8 +: 8];
  end
  assign parity = chain[LANES];
endmodule

// File: rtl/bip8_popcnt.sv
module bip8_popcnt (
  input  logic [7:0] vec,
  output logic [3:0] count
);
  logic [3:0] sum [9];

  assign sum[0] = 4'd0;
  for (genvar g = 0; g < 8; g++) begin : g_bit
    assign sum[g+1] = sum[g] + {3'b000, vec[g]};
  end
  assign count = sum[8];
endmodule

// File: rtl/bip8_ctx_store.sv
module bip8_ctx_store
  import bip8_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PW        = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PW-1:0]     rd_idx,
  output port_ctx_t         rd_ctx,
  input  logic              wr_en,
  input  logic [PW-1:0]     wr_idx,
  input  port_ctx_t         wr_ctx
);
  port_ctx_t ctx_q [NUM_PORTS];

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == PW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctx_q[g] <= '0;
      end else if (hit) begin
        ctx_q[g] <= wr_ctx;
      end
    end
  end

  always_comb begin
    rd_ctx = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (rd_idx == PW'(i)) rd_ctx = ctx_q[i];
    end
  end
endmodule

// File: rtl/bip8_ctx_engine.sv
module bip8_ctx_engine
  import bip8_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned LANES     = 9,
  parameter int unsigned PW        = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [PW-1:0]      in_port,
  input  logic [LANES*8-1:0] in_data,
  input  logic               in_sof,
  input  logic               in_b1pos,
  input  logic               in_dup,
  output logic               chk_valid,
  output logic [PW-1:0]      chk_port,
  output logic               b1_err,
  output logic [3:0]         err_bits
);
  // working register: the context being rewritten this cycle
  port_ctx_t  cur_ctx;
  port_ctx_t  nxt_ctx;
  logic [7:0] word_par;
  logic       port_ok;
  logic       take;
  logic [7:0] exp_now;
  logic       exp_now_vld;
  logic [7:0] diff;
  logic [3:0] diff_cnt;

  logic          chk_valid_d, b1_err_d;
  logic [PW-1:0] chk_port_d;
  logic [3:0]    err_bits_d;

  bip8_lane_fold #(.LANES(LANES)) u_fold (
    .word   (in_data),
    .parity (word_par)
  );

  bip8_ctx_store #(.NUM_PORTS(NUM_PORTS), .PW(PW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (in_port),
    .rd_ctx (cur_ctx),
    .wr_en  (take),
    .wr_idx (in_port),
    .wr_ctx (nxt_ctx)
  );

  bip8_popcnt u_pop (
    .vec   (diff),
    .count (diff_cnt)
  );

  assign port_ok = (32'(in_port) < NUM_PORTS);
  assign take    = in_valid && !in_dup && port_ok;

  // context update
  always_comb begin
    nxt_ctx = cur_ctx;
    if (in_sof) begin
      nxt_ctx.exp     = cur_ctx.acc;
      nxt_ctx.exp_vld = cur_ctx.primed;
      nxt_ctx.primed  = 1'b1;
      nxt_ctx.acc     = word_par;
    end else begin
      nxt_ctx.acc     = cur_ctx.acc ^ word_par;
    end
  end

  // comparison against the value valid for this word
  always_comb begin
    exp_now     = in_sof ? cur_ctx.acc    : cur_ctx.exp;
    exp_now_vld = in_sof ? cur_ctx.primed : cur_ctx.exp_vld;
    diff        = exp_now ^ in_data[7:0];
  end

  always_comb begin
    chk_valid_d = take && in_b1pos && exp_now_vld;
    chk_port_d  = chk_valid_d ? in_port : '0;
    err_bits_d  = chk_valid_d ? diff_cnt : 4'd0;
    b1_err_d    = chk_valid_d && (diff != 8'h00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_valid <= 1'b0;
      chk_port  <= '0;
      b1_err    <= 1'b0;
      err_bits  <= 4'd0;
    end else begin
      chk_valid <= chk_valid_d;
      chk_port  <= chk_port_d;
      b1_err    <= b1_err_d;
      err_bits  <= err_bits_d;
    end
  end
endmodule

// File: rtl/bip8_ctx_engine_chk.sv
module bip8_ctx_engine_chk #(
  parameter int unsigned PW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [PW-1:0] in_port,
  input logic          in_b1pos,
  input logic          in_dup,
  input logic          chk_valid,
  input logic [PW-1:0] chk_port,
  input logic          b1_err,
  input logic [3:0]    err_bits
);
  a_r4_pulse_needs_b1: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> $past(in_valid && in_b1pos && !in_dup));

  a_r4_port_follows: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> (chk_port == $past(in_port)));

  a_r5_err_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    b1_err |-> chk_valid);

  a_r5_err_vs_count: assert property (@(posedge clk) disable iff (!rst_n)
    b1_err == (err_bits != 4'd0));

  a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    err_bits <= 4'd8);

  a_r6_dup_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_dup) |=> !chk_valid);

  a_r10_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !chk_valid);
endmodule

bind bip8_ctx_engine bip8_ctx_engine_chk #(.PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_port   (in_port),
  .in_b1pos  (in_b1pos),
  .in_dup    (in_dup),
  .chk_valid (chk_valid),
  .chk_port  (chk_port),
  .b1_err    (b1_err),
  .err_bits  (err_bits)
);

// File: tb/bip8_ctx_engine_bench.sv
`timescale 1ns/1ps
module bip8_ctx_engine_bench;
  localparam int NP    = 4;
  localparam int LN    = 9;
  localparam int PWB   = 2;
  localparam int FLEN  = 5;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic [PWB-1:0]  in_port;
  logic [LN*8-1:0] in_data;
  logic            in_sof, in_b1pos, in_dup;
  logic            chk_valid;
  logic [PWB-1:0]  chk_port;
  logic            b1_err;
  logic [3:0]      err_bits;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0] ref_acc [NP];
  logic [7:0] ref_exp [NP];
  bit         ref_primed [NP];
  bit         ref_vld [NP];
  int         pos [NP];

  bip8_ctx_engine #(.NUM_PORTS(NP), .LANES(LN)) u_bip8_ctx_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_port(in_port),
    .in_data(in_data), .in_sof(in_sof), .in_b1pos(in_b1pos), .in_dup(in_dup),
    .chk_valid(chk_valid), .chk_port(chk_port), .b1_err(b1_err), .err_bits(err_bits)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] fold(input logic [LN*8-1:0] d);
    logic [7:0] r = 8'h00;
    for (int k = 0; k < LN; k++) r ^= d[k*8 +: 8];
    return r;
  endfunction

  function automatic int pop8(input logic [7:0] v);
    int n = 0;
    for (int k = 0; k < 8; k++) n += int'(v[k]);
    return n;
  endfunction

  function automatic logic [LN*8-1:0] rnd_word();
    logic [LN*8-1:0] w;
    for (int k = 0; k < LN; k++) w[k*8 +: 8] = 8'($urandom);
    return w;
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic send(input int p, input logic [LN*8-1:0] d, input bit sof,
                      input bit b1, input bit dup, input bit v, input string tag);
    bit e_chk = 0;
    int e_bits = 0;
    logic [7:0] en, fw;
    in_valid = v; in_port = PWB'(p); in_data = d;
    in_sof = sof; in_b1pos = b1; in_dup = dup;
    if (v && !dup) begin
      fw = fold(d);
      en = sof ? ref_acc[p] : ref_exp[p];
      if (b1 && (sof ? ref_primed[p] : ref_vld[p])) begin
        e_chk  = 1;
        e_bits = pop8(en ^ d[7:0]);
      end
      if (sof) begin
        ref_exp[p]    = ref_acc[p];
        ref_vld[p]    = ref_primed[p];
        ref_primed[p] = 1;
        ref_acc[p]    = fw;
      end else begin
        ref_acc[p] = ref_acc[p] ^ fw;
      end
    end
    @(posedge clk);
    #2;
    in_valid = 0; in_sof = 0; in_b1pos = 0; in_dup = 0;
    checks++;
    if (chk_valid !== e_chk ||
        (e_chk && (chk_port !== PWB'(p) || err_bits !== 4'(e_bits) ||
                   b1_err !== (e_bits != 0))) ||
        (!e_chk && (b1_err !== 1'b0 || err_bits !== 4'd0))) begin
      errors++;
      $display("FAIL %s: port %0d actual chk=%0b port=%0d err=%0b bits=%0d expected chk=%0b port=%0d err=%0b bits=%0d",
               tag, p, chk_valid, chk_port, b1_err, err_bits,
               e_chk, p, (e_bits != 0), e_bits);
    end
    @(negedge clk);
  endtask

  // one generated word of a port's frame; mask flips bits of the parity byte
  task automatic frame_word(input int p, input logic [7:0] mask, input string tag);
    logic [LN*8-1:0] d = rnd_word();
    bit s = (pos[p] == 0);
    bit b = (pos[p] == 1);
    if (b) d[7:0] = ref_exp[p] ^ mask;
    send(p, d, s, b, 0, 1, tag);
    pos[p] = (pos[p] + 1) % FLEN;
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_b1b1);
    for (int i = 0; i < NP; i++) begin
      ref_acc[i] = 0; ref_exp[i] = 0; ref_primed[i] = 0; ref_vld[i] = 0; pos[i] = 0;
    end
    rst_n = 0; in_valid = 0; in_port = 0; in_data = '0;
    in_sof = 0; in_b1pos = 0; in_dup = 0;
    repeat (3) @(posedge clk);
    #3;
    checks++;
    if (chk_valid !== 0 || b1_err !== 0 || err_bits !== 0) begin
      errors++;
      $display("FAIL R1: actual chk=%0b err=%0b bits=%0d expected 0 0 0", chk_valid, b1_err, err_bits);
    end
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R8: no result before two starts of frame
    send(0, rnd_word(), 0, 1, 0, 1, "R8 before any frame");
    send(0, rnd_word(), 1, 0, 0, 1, "R8 first sof");
    send(0, rnd_word(), 0, 1, 0, 1, "R8 b1 in first frame");
    send(1, rnd_word(), 1, 0, 0, 1, "R7 other port sof");
    send(0, rnd_word(), 0, 0, 0, 1, "R2 fold");
    send(0, rnd_word(), 0, 0, 0, 1, "R7 back to back");
    send(0, rnd_word(), 1, 0, 0, 1, "R3 second sof");
    begin
      logic [LN*8-1:0] d = rnd_word();
      d[7:0] = ref_exp[0];
      send(0, d, 0, 1, 0, 1, "R4 R2 clean compare");
    end
    // R6: duplicate with parity marker and wrong byte
    send(0, {rnd_word()}, 0, 1, 1, 1, "R6 dup ignored");
    send(0, rnd_word(), 0, 0, 1, 1, "R6 dup not folded");
    // R10: idle cycle with markers set
    send(0, rnd_word(), 1, 1, 0, 0, "R10 idle");
    send(0, rnd_word(), 1, 0, 0, 1, "R3 third sof");
    begin
      logic [LN*8-1:0] d = rnd_word();
      d[7:0] = ~ref_exp[0];
      send(0, d, 0, 1, 0, 1, "R5 all bits wrong");
    end
    // R9: start of frame and parity byte in one word
    begin
      logic [LN*8-1:0] d = rnd_word();
      d[7:0] = ref_acc[0] ^ 8'h0F;
      send(0, d, 1, 1, 0, 1, "R9 sof with b1");
    end
    send(1, rnd_word(), 1, 0, 0, 1, "R8 port1 second sof");
    begin
      logic [LN*8-1:0] d = rnd_word();
      d[7:0] = ref_exp[1] ^ 8'h01;
      send(1, d, 0, 1, 0, 1, "R5 single bit");
    end

    // R7: random interleaving of all ports against the model
    for (int p = 0; p < NP; p++) pos[p] = 0;
    for (int n = 0; n < 4000; n++) begin
      int p = int'($urandom_range(NP-1, 0));
      int r = int'($urandom_range(99, 0));
      if (r < 8) begin
        send(p, rnd_word(), 1'($urandom), 1'($urandom), 1, 1, "R6 random dup");
      end else if (r < 15) begin
        send(p, rnd_word(), 1'($urandom), 1'($urandom), 0, 0, "R10 random idle");
      end else begin
        logic [7:0] m = ($urandom_range(2, 0) == 0) ? 8'($urandom) : 8'h00;
        frame_word(p, m, "R7 interleaved");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule